// File: doc/BRIEF.md
# Round-Robin ADC Thermal Monitor

This block keeps a shared 8-bit converter busy by visiting three analog inputs in a fixed circular order. The order is the temperature-sense input, then the load-current monitor, then an auxiliary input. Each visit lasts a fixed slot. The slot is 30 us by default, so one full pass takes 90 us. At the start of each slot the block issues a one-cycle conversion request and holds the channel select steady. It then stores the first completed result of that slot in a small result bank. A read port returns the bank contents by address.

The temperature-sense voltage falls as temperature rises. Every new temperature result feeds two active-low flags, each with its own assert and release code. The warning flag asserts at or below about 491 mV and releases at or above about 513 mV. The overheat flag asserts at or below about 472 mV and releases at or above about 494 mV. With 2.0 V spread over 256 codes, these levels round to codes 63/66 and 60/63. Samples from the other two channels never move either flag.

Top module: `thermon_rr_monitor`

## Requirements
- R1: While reset is held and after its release, `alert_n` and `hot_n` are 1 and every stored result reads 0 until that channel's first accepted conversion.
- R2: `adc_start` is a single-cycle pulse in the first cycle of each slot, and consecutive pulses are exactly SLOT_CYCLES cycles apart.
- R3: `adc_chan` follows the order 0 (temperature), 1 (load current), 2 (auxiliary), then back to 0. It changes only in a cycle where `adc_start` is high, and the first slot after reset uses channel 0.
- R4: Only the first `adc_done` after a slot's start cycle is stored. A strobe in the start cycle itself, or any later strobe in the same slot, leaves the bank and flags unchanged.
- R5: An accepted result is readable on `rd_data` from the next cycle. Temperature is at address 0x17, load current at 0x15 and auxiliary at 0x16. Any other address reads 0, and the read path is combinational.
- R6: On each new temperature result, a code at or below 63 drives `alert_n` to 0 and a code at or above 66 drives it to 1. Codes in between keep the previous level.
- R7: On each new temperature result, a code at or below 60 drives `hot_n` to 0 and a code at or above 63 drives it to 1. Codes in between keep the previous level.
- R8: Both flags change only in the cycle after a temperature result is accepted. Results on channels 1 and 2 never change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_done | input | 1 | Conversion complete strobe from the converter |
| adc_data | input | 8 | Conversion result, valid with `adc_done` |
| rd_addr | input | 8 | Result bank read address |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 2 | Analog channel select |
| rd_data | output | 8 | Result at `rd_addr`, or 0 if unmapped |
| alert_n | output | 1 | Active-low thermal warning flag |
| hot_n | output | 1 | Active-low overheat flag |

## Verification
The bench builds the block with SLOT_CYCLES set to 16, which makes a full three-slot pass 48 cycles long. This lets many passes run and lets the slot spacing be measured directly. The thresholds keep their default codes, so the table walks temperature codes across both hysteresis bands: the exact set and release codes, codes one step inside each band, and the extremes 0 and 255. The directed tests place stray strobes in the start cycle and after acceptance, and probe unmapped addresses.

// File: rtl/thermon_pkg.sv
package thermon_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;

  typedef enum logic [CH_W-1:0] {
    CH_TEMP = 2'd0,
    CH_IMON = 2'd1,
    CH_AUX  = 2'd2
  } chan_e;
endpackage

// File: rtl/rr_slot_timer.sv
module rr_slot_timer
  import thermon_pkg::*;
#(
  parameter int SLOT_CYCLES = 3750
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_done,
  output logic            start,
  output logic [CH_W-1:0] chan,
  output logic            accept
);
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             busy_q, busy_d;
  logic             cnt_last;

  always_comb begin
    cnt_last = (cnt_q == CNT_LAST);
    start    = (cnt_q == '0);
    accept   = adc_done & busy_q;
    cnt_d    = cnt_last ? '0 : cnt_q + CNT_W'(1);
    chan_d   = chan_q;
    if (cnt_last) begin
      chan_d = (chan_q == CH_LAST) ? '0 : chan_q + CH_W'(1);
    end
    busy_d = busy_q;
    if (cnt_last) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
    end else if (accept) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      chan_q <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
      busy_q <= busy_d;
    end
  end

  assign chan = chan_q;
endmodule

// File: rtl/result_bank.sv
module result_bank
  import thermon_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_TEMP = 8'h17,
  parameter logic [ADDR_W-1:0] ADDR_IMON = 8'h15,
  parameter logic [ADDR_W-1:0] ADDR_AUX  = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] ADDR_MAP [NUM_CH] = '{ADDR_TEMP, ADDR_IMON, ADDR_AUX};

  logic [DATA_W-1:0] slot_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic wr_hit;
    assign wr_hit = wr_en && (wr_chan == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_hit) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_MAP[i]) begin
        rd_data = slot_q[i];
      end
    end
  end
endmodule

// File: rtl/hyst_flag.sv
module hyst_flag #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] SET_CODE = 8'd63,
  parameter logic [DATA_W-1:0] CLR_CODE = 8'd66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_code,
  output logic              flag_n
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (smp_valid) begin
      if (smp_code <= SET_CODE) begin
        flag_d = 1'b0;
      end else if (smp_code >= CLR_CODE) begin
        flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_n = flag_q;
endmodule

// File: rtl/thermon_rr_monitor.sv
module thermon_rr_monitor
  import thermon_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter int                SLOT_CYCLES = 3750,
  parameter logic [ADDR_W-1:0] ADDR_TEMP = 8'h17,
  parameter logic [ADDR_W-1:0] ADDR_IMON = 8'h15,
  parameter logic [ADDR_W-1:0] ADDR_AUX  = 8'h16,
  parameter logic [DATA_W-1:0] ALERT_SET = 8'd63,
  parameter logic [DATA_W-1:0] ALERT_CLR = 8'd66,
  parameter logic [DATA_W-1:0] HOT_SET   = 8'd60,
  parameter logic [DATA_W-1:0] HOT_CLR   = 8'd63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  output logic [DATA_W-1:0] rd_data,
  output logic              alert_n,
  output logic              hot_n
);
  logic accept;
  logic temp_wr;

  rr_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_done (adc_done),
    .start    (adc_start),
    .chan     (adc_chan),
    .accept   (accept)
  );

  result_bank #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ADDR_TEMP (ADDR_TEMP),
    .ADDR_IMON (ADDR_IMON),
    .ADDR_AUX  (ADDR_AUX)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_chan (adc_chan),
    .wr_data (adc_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign temp_wr = accept && (adc_chan == CH_TEMP);

  hyst_flag #(.DATA_W(DATA_W), .SET_CODE(ALERT_SET), .CLR_CODE(ALERT_CLR)) u_alert (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (temp_wr),
    .smp_code  (adc_data),
    .flag_n    (alert_n)
  );

  hyst_flag #(.DATA_W(DATA_W), .SET_CODE(HOT_SET), .CLR_CODE(HOT_CLR)) u_hot (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (temp_wr),
    .smp_code  (adc_data),
    .flag_n    (hot_n)
  );
endmodule

// File: rtl/thermon_rr_checker.sv
module thermon_rr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_start,
  input logic [1:0] adc_chan,
  input logic       alert_n,
  input logic       hot_n,
  input logic       temp_wr
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r3_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_start |-> $stable(adc_chan));

  a_r3_chan_order: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_chan != $past(adc_chan)) |->
      (adc_chan == (($past(adc_chan) == 2'd2) ? 2'd0 : $past(adc_chan) + 2'd1)));

  a_r3_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    adc_chan != 2'd3);

  a_r8_alert_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_wr |=> $stable(alert_n));

  a_r8_hot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_wr |=> $stable(hot_n));

  // R6 R7: with the default codes an overheat state always lies inside the warning state
  a_r7_hot_within_alert: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_n |-> !alert_n);
endmodule

bind thermon_rr_monitor thermon_rr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_start (adc_start),
  .adc_chan  (adc_chan),
  .alert_n   (alert_n),
  .hot_n     (hot_n),
  .temp_wr   (temp_wr)
);

// File: tb/thermon_rr_monitor_bench.sv
module thermon_rr_monitor_bench;
  localparam int SLOT = 16;
  localparam int NV   = 11;
  // {alert_n, hot_n, temp, imon, aux}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd100, 8'd5,   8'd200},
    {1'b1, 1'b1, 8'd64,  8'd40,  8'd1},
    {1'b0, 1'b1, 8'd63,  8'd10,  8'd2},
    {1'b0, 1'b1, 8'd65,  8'd200, 8'd3},
    {1'b0, 1'b1, 8'd61,  8'd0,   8'd4},
    {1'b0, 1'b0, 8'd60,  8'd90,  8'd5},
    {1'b0, 1'b0, 8'd62,  8'd70,  8'd6},
    {1'b0, 1'b1, 8'd63,  8'd20,  8'd7},
    {1'b1, 1'b1, 8'd66,  8'd1,   8'd8},
    {1'b0, 1'b0, 8'd0,   8'd255, 8'd9},
    {1'b1, 1'b1, 8'd255, 8'd33,  8'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adc_done = 1'b0;
  logic [7:0] adc_data = '0;
  logic [7:0] rd_addr = '0;
  logic       adc_start;
  logic [1:0] adc_chan;
  logic [7:0] rd_data;
  logic       alert_n, hot_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  thermon_rr_monitor #(.SLOT_CYCLES(SLOT)) u_thermon_rr_monitor (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .adc_data(adc_data),
    .rd_addr(rd_addr), .adc_start(adc_start), .adc_chan(adc_chan),
    .rd_data(rd_data), .alert_n(alert_n), .hot_n(hot_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // wait for a slot start, check channel, deliver one result
  task automatic serve(input int exp_chan, input logic [7:0] data);
    while (!adc_start) @(negedge clk);
    check("R3 channel order", adc_chan, exp_chan);
    repeat (2) @(negedge clk);
    adc_done = 1'b1;
    adc_data = data;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] last_imon;
    int n;
    repeat (3) @(negedge clk);
    // R1 values during reset
    check("R1 alert_n in reset", alert_n, 1);
    check("R1 hot_n in reset", hot_n, 1);
    rst_n = 1'b1;
    // first cycle after release
    check("R2 start after reset", adc_start, 1);
    check("R3 first channel", adc_chan, 0);
    read_at(8'h17, d); check("R1 temp zero", d, 0);
    read_at(8'h15, d); check("R1 imon zero", d, 0);
    read_at(8'h16, d); check("R1 aux zero", d, 0);
    check("R1 alert_n after reset", alert_n, 1);
    check("R1 hot_n after reset", hot_n, 1);

    last_imon = '0;
    for (int i = 0; i < NV; i++) begin
      logic exp_a, exp_h;
      exp_a = VEC[i][25];
      exp_h = VEC[i][24];
      serve(0, VEC[i][23:16]);
      read_at(8'h17, d); check("R5 temp at 0x17", d, VEC[i][23:16]);
      check("R6 alert_n", alert_n, exp_a);
      check("R7 hot_n", hot_n, exp_h);
      serve(1, VEC[i][15:8]);
      read_at(8'h15, d); check("R5 imon at 0x15", d, VEC[i][15:8]);
      check("R8 alert_n after imon", alert_n, exp_a);
      check("R8 hot_n after imon", hot_n, exp_h);
      serve(2, VEC[i][7:0]);
      read_at(8'h16, d); check("R5 aux at 0x16", d, VEC[i][7:0]);
      check("R8 alert_n after aux", alert_n, exp_a);
      last_imon = VEC[i][15:8];
    end

    // R4: second strobe in the same slot is ignored (temp slot, flags idle high)
    serve(0, 8'd100);
    @(negedge clk);
    adc_done = 1'b1; adc_data = 8'd10;
    @(negedge clk);
    adc_done = 1'b0;
    @(negedge clk);
    read_at(8'h17, d); check("R4 extra strobe ignored", d, 100);
    check("R4 alert_n unchanged", alert_n, 1);
    check("R4 hot_n unchanged", hot_n, 1);

    // R4: strobe in the start cycle is ignored (imon slot)
    while (!adc_start) @(negedge clk);
    check("R3 imon slot", adc_chan, 1);
    adc_done = 1'b1; adc_data = 8'd77;
    @(negedge clk);
    adc_done = 1'b0;
    repeat (SLOT) @(negedge clk);
    read_at(8'h15, d); check("R4 start-cycle strobe ignored", d, last_imon);

    // R2: slot spacing
    while (!adc_start) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check("R2 single-cycle start", adc_start, 0);
    end while (!adc_start && n < 4 * SLOT);
    check("R2 slot spacing", n, SLOT);

    // R5: unmapped addresses read zero
    read_at(8'h00, d); check("R5 unmapped 0x00", d, 0);
    read_at(8'h18, d); check("R5 unmapped 0x18", d, 0);
    read_at(8'h14, d); check("R5 unmapped 0x14", d, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule